// File: doc/BRIEF.md
# Fly-by DMA Channel Controller

This block is one channel of a fly-by DMA engine. When a peripheral raises its request line, the controller asks the CPU for the bus. Once the bus is granted, the controller drives a memory address and a pair of bus strobes, so that the peripheral and the memory exchange one word directly over the shared data bus. The controller never sees or stores the data. It only sequences the bus ownership handshake, the peripheral acknowledge, the strobes and the address.

Software programs four things through a small write port: a start address, a word count, a direction and a mode. The mode is either single or burst. In single mode the bus is handed back after every word, and a new grant is needed for the next one. In burst mode the bus is kept until the whole block has moved. When the last word completes, a one-cycle terminal-count pulse is raised and the channel disables itself.

Top module: `flyby_dma`

## Requirements
- R1: After reset, hrq, dack, bus_oe, tc and all four strobes are low, mem_addr is zero and the channel is disabled.
- R2: With the channel enabled, hrq rises in the cycle after dreq is sampled high. It stays high until the word that ends the handshake has been strobed.
- R3: bus_oe, dack and the strobes are high only in a cycle whose previous cycle sampled both hrq and hlda high.
- R4: Each word is exactly one cycle with one strobe pair high. Direction bit 1 of the control register selects the pair: 0 gives memw with ior (I/O to memory), and 1 gives memr with iow (memory to I/O).
- R5: dack is high in exactly the cycles in which a strobe pair is high.
- R6: During a strobe cycle, mem_addr equals the start address plus the number of words already moved, modulo 2^ADDR_W. While bus_oe is low, mem_addr is zero.
- R7: After the final word, tc is high for exactly one cycle and hrq is low. The channel then ignores dreq until it is enabled again.
- R8: In single mode (control bit 2 = 0), hrq drops for at least one cycle after every word, even while dreq stays high.
- R9: In burst mode (control bit 2 = 1), hrq stays high between words. With dreq and hlda both held, words move on consecutive cycles.
- R10: If dreq drops while a single-mode request is waiting for hlda, hrq falls on the next cycle. A burst-mode request keeps hrq high.
- R11: Register writes are ignored while the channel is enabled. cfg_sel selects the register: 0 = address, 1 = count, 2 = control (bit 0 enable, bit 1 direction, bit 2 burst).
- R12: Setting the enable bit while the count is zero leaves the channel disabled.
- R13: If hlda falls during a burst, the strobes stop from the next cycle on, hrq stays high, and transfers resume once hlda returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | REG_W | Register write data |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Peripheral acknowledge |
| hrq | output | 1 | Bus request to the CPU |
| hlda | input | 1 | Bus grant from the CPU |
| bus_oe | output | 1 | Drive enable for address and strobes |
| mem_addr | output | ADDR_W | Memory address |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| ior | output | 1 | I/O read strobe |
| iow | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal-count pulse |

## Verification
The bound checker tests these rules on every cycle: the bus is never driven without a grant sampled in the previous cycle, there is never more than one strobe pair, dack matches the strobes, the released address reads zero, the address steps by one within a burst, tc lasts a single cycle with hrq low, and hrq is released after each single-mode word. The bench's scenarios cover the remaining rules. These are the word totals per block, address wrap-around, re-arbitration while dreq stays high, a grant withdrawn mid-burst, writes ignored while the channel is busy, and a zero-count enable. The bench runs a behavioural model in step with the design and compares every output on every clock.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_MOVE = 2'd2
    } phase_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_DIR_BIT   = 1;
    localparam int CTRL_BURST_BIT = 2;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              chan_en,
    output logic              chan_dir,
    output logic              chan_burst,
    output logic              last_word,
    output logic              tc_pulse
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              en;
        logic              dir;
        logic              burst;
        logic              tc;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.tc = 1'b0;
        if (cfg_we && !r_q.en) begin
            case (cfg_sel)
                SEL_ADDR:  r_d.addr = cfg_wdata[ADDR_W-1:0];
                SEL_COUNT: r_d.cnt  = cfg_wdata[CNT_W-1:0];
                SEL_CTRL: begin
                    r_d.dir   = cfg_wdata[CTRL_DIR_BIT];
                    r_d.burst = cfg_wdata[CTRL_BURST_BIT];
                    r_d.en    = cfg_wdata[CTRL_EN_BIT] && (r_q.cnt != '0);
                end
                default: ;
            endcase
        end
        if (step && r_q.en) begin
            r_d.addr = r_q.addr + ADDR_ONE;
            r_d.cnt  = r_q.cnt - CNT_ONE;
            if (r_q.cnt == CNT_ONE) begin
                r_d.en = 1'b0;
                r_d.tc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cur_addr   = r_q.addr;
    assign chan_en    = r_q.en;
    assign chan_dir   = r_q.dir;
    assign chan_burst = r_q.burst;
    assign last_word  = (r_q.cnt == CNT_ONE);
    assign tc_pulse   = r_q.tc;

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import flyby_dma_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   dreq,
    input  logic   hlda,
    input  logic   chan_en,
    input  logic   chan_burst,
    input  logic   last_word,
    output phase_e phase,
    output logic   step
);

    typedef struct packed {
        phase_e ph;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_IDLE: begin
                if (chan_en && dreq) s_d.ph = PH_WAIT;
            end
            PH_WAIT: begin
                if (hlda && dreq)             s_d.ph = PH_MOVE;
                else if (!chan_burst && !dreq) s_d.ph = PH_IDLE;
            end
            PH_MOVE: begin
                if (last_word || !chan_burst) s_d.ph = PH_IDLE;
                else if (hlda && dreq)        s_d.ph = PH_MOVE;
                else                          s_d.ph = PH_WAIT;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE};
        else        s_q <= s_d;
    end

    assign phase = s_q.ph;
    assign step  = (s_q.ph == PH_MOVE);

endmodule

// File: rtl/dma_bus_drive.sv
module dma_bus_drive
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  phase_e            phase,
    input  logic              chan_dir,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              hrq,
    output logic              bus_oe,
    output logic              dack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              memr,
    output logic              memw,
    output logic              ior,
    output logic              iow
);

    logic moving;

    always_comb begin
        moving   = (phase == PH_MOVE);
        hrq      = (phase != PH_IDLE);
        bus_oe   = moving;
        dack     = moving;
        mem_addr = moving ? cur_addr : '0;
        memr     = moving &&  chan_dir;
        iow      = moving &&  chan_dir;
        memw     = moving && !chan_dir;
        ior      = moving && !chan_dir;
    end

endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              dreq,
    output logic              dack,
    output logic              hrq,
    input  logic              hlda,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              memr,
    output logic              memw,
    output logic              ior,
    output logic              iow,
    output logic              tc
);

    logic [ADDR_W-1:0] cur_addr;
    logic              ctl_en, ctl_dir, ctl_burst, last_word, step;
    phase_e            phase;

    dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .step(step), .cur_addr(cur_addr),
        .chan_en(ctl_en), .chan_dir(ctl_dir), .chan_burst(ctl_burst),
        .last_word(last_word), .tc_pulse(tc)
    );

    dma_chan_seq u_seq (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .hlda(hlda),
        .chan_en(ctl_en), .chan_burst(ctl_burst), .last_word(last_word),
        .phase(phase), .step(step)
    );

    dma_bus_drive #(.ADDR_W(ADDR_W)) u_drive (
        .phase(phase), .chan_dir(ctl_dir), .cur_addr(cur_addr),
        .hrq(hrq), .bus_oe(bus_oe), .dack(dack), .mem_addr(mem_addr),
        .memr(memr), .memw(memw), .ior(ior), .iow(iow)
    );

endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hrq,
    input logic              hlda,
    input logic              dack,
    input logic              bus_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              memr,
    input logic              memw,
    input logic              ior,
    input logic              iow,
    input logic              tc,
    input logic              burst
);

    a_r3_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe || dack || memr || memw || ior || iow) |-> ($past(hlda) && $past(hrq)));

    a_r4_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({memw && ior, memr && iow}) && !(memr && memw) && !(ior && iow));

    a_r5_dack_matches: assert property (@(posedge clk) disable iff (!rst_n)
        dack == ((memw && ior) || (memr && iow)));

    a_r6_released_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (mem_addr == '0));

    a_r6_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && $past(dack) && $past(rst_n)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    a_r7_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);

    a_r7_tc_released: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> !hrq);

    a_r8_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dack) && !burst) |-> !hrq);

endmodule

bind flyby_dma flyby_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hrq(hrq), .hlda(hlda), .dack(dack),
    .bus_oe(bus_oe), .mem_addr(mem_addr), .memr(memr), .memw(memw),
    .ior(ior), .iow(iow), .tc(tc), .burst(ctl_burst)
);

// File: tb/sim_flyby_dma.sv
module sim_flyby_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        dreq = 1'b0;
    logic        hlda = 1'b0;
    logic        dack, hrq, bus_oe, memr, memw, ior, iow, tc;
    logic [15:0] mem_addr;

    always #4 clk = ~clk;

    flyby_dma u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack), .hrq(hrq),
        .hlda(hlda), .bus_oe(bus_oe), .mem_addr(mem_addr), .memr(memr),
        .memw(memw), .ior(ior), .iow(iow), .tc(tc)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit auto_grant = 1'b0;

    // behavioural reference
    int        m_st;
    bit [15:0] m_addr, m_cnt;
    bit        m_en, m_dir, m_burst, m_tc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_cnt = 0;
            m_en = 0; m_dir = 0; m_burst = 0; m_tc = 0;
        end else begin
            int  nst;
            bit  moved;
            bit  was_en;
            moved  = (m_st == 2);
            was_en = m_en;
            nst    = m_st;
            if (m_st == 0) begin
                if (m_en && dreq) nst = 1;
            end else if (m_st == 1) begin
                if (hlda && dreq) nst = 2;
                else if (!m_burst && !dreq) nst = 0;
            end else begin
                if (m_cnt == 1 || !m_burst) nst = 0;
                else if (hlda && dreq) nst = 2;
                else nst = 1;
            end
            m_tc = 0;
            if (cfg_we && !was_en) begin
                if (cfg_sel == 0) m_addr = cfg_wdata;
                else if (cfg_sel == 1) m_cnt = cfg_wdata;
                else if (cfg_sel == 2) begin
                    m_dir   = cfg_wdata[1];
                    m_burst = cfg_wdata[2];
                    m_en    = cfg_wdata[0] && (m_cnt != 0);
                end
            end
            if (moved) begin
                m_addr = m_addr + 1;
                m_cnt  = m_cnt - 1;
                if (m_cnt == 0) begin m_en = 0; m_tc = 1; end
            end
            m_st = nst;
        end
    end

    // observation counters
    int        words = 0, hrq_rises = 0, tc_seen = 0;
    bit        prev_hrq = 0;
    bit [15:0] first_addr, last_addr;
    bit        first_taken = 0;
    int        pair_rd = 0, pair_wr = 0;

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            bit [3:0] exp_str;
            exp_str = (m_st == 2) ? (m_dir ? 4'b1001 : 4'b0110) : 4'b0000;
            cmp("R2 hrq", hrq, m_st != 0);
            cmp("R3 bus_oe", bus_oe, m_st == 2);
            cmp("R5 dack", dack, m_st == 2);
            cmp("R4 strobes{memr,memw,ior,iow}", {memr, memw, ior, iow}, exp_str);
            cmp("R6 mem_addr", mem_addr, (m_st == 2) ? m_addr : 16'd0);
            cmp("R7 tc", tc, m_tc);
            if (dack) begin
                words++;
                if (!first_taken) begin first_addr = mem_addr; first_taken = 1; end
                last_addr = mem_addr;
                if (memr && iow) pair_rd++;
                if (memw && ior) pair_wr++;
            end
            if (hrq && !prev_hrq) hrq_rises++;
            if (tc) tc_seen++;
            prev_hrq = hrq;
        end
        if (auto_grant) hlda = hrq;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic wr(input bit [1:0] sel, input bit [15:0] val);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic clear_obs();
        words = 0; hrq_rises = 0; tc_seen = 0; first_taken = 0;
        pair_rd = 0; pair_wr = 0;
    endtask

    task automatic wait_tc();
        int n = 0;
        while (tc_seen == 0 && n < 500) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1 hrq", hrq, 0);
        cmp("R1 outputs", {dack, bus_oe, memr, memw, ior, iow, tc}, 0);
        cmp("R1 mem_addr", mem_addr, 0);
        rst_n = 1;
        dreq = 1;
        repeat (4) @(negedge clk);
        cmp("R1 disabled ignores dreq", hrq, 0);
        dreq = 0;

        // single mode, I/O to memory, three words, dreq held (R8)
        clear_obs();
        auto_grant = 1;
        wr(0, 16'h1230); wr(1, 16'd3); wr(2, 16'b001);
        dreq = 1;
        wait_tc();
        cmp("R4 single word count", words, 3);
        cmp("R4 io2mem pair used", pair_wr, 3);
        cmp("R8 one arbitration per word", hrq_rises, 3);
        cmp("R6 first address", first_addr, 16'h1230);
        cmp("R6 last address", last_addr, 16'h1232);
        cmp("R7 one tc", tc_seen, 1);
        repeat (5) @(negedge clk);
        cmp("R7 disabled after tc", hrq, 0);
        dreq = 0;

        // burst, memory to I/O, wraps address (R9)
        clear_obs();
        wr(0, 16'hFFFE); wr(1, 16'd4); wr(2, 16'b111);
        dreq = 1;
        wait_tc();
        cmp("R9 burst word count", words, 4);
        cmp("R9 single arbitration", hrq_rises, 1);
        cmp("R4 mem2io pair used", pair_rd, 4);
        cmp("R6 wrapped last address", last_addr, 16'h0001);
        dreq = 0;

        // burst with grant withdrawn (R13)
        clear_obs();
        auto_grant = 0; hlda = 0;
        wr(0, 16'h0400); wr(1, 16'd6); wr(2, 16'b101);
        dreq = 1;
        @(negedge clk); hlda = 1;
        repeat (3) @(negedge clk);
        hlda = 0;
        repeat (2) @(negedge clk);
        cmp("R13 strobes stop", dack, 0);
        cmp("R13 hrq held", hrq, 1);
        repeat (3) @(negedge clk);
        cmp("R13 no words while released", dack, 0);
        hlda = 1;
        wait_tc();
        cmp("R13 total words", words, 6);
        cmp("R13 last address", last_addr, 16'h0405);
        hlda = 0; dreq = 0;

        // single mode request withdrawn before grant (R10)
        wr(0, 16'h0010); wr(1, 16'd1); wr(2, 16'b001);
        dreq = 1;
        repeat (3) @(negedge clk);
        cmp("R10 waiting request", hrq, 1);
        dreq = 0;
        @(negedge clk);
        cmp("R10 single drops hrq", hrq, 0);

        // writes ignored while enabled (R11)
        wr(0, 16'h0500);
        wr(1, 16'd9);
        clear_obs();
        auto_grant = 1;
        dreq = 1;
        wait_tc();
        cmp("R11 address write ignored", first_addr, 16'h0010);
        cmp("R11 count write ignored", words, 1);
        dreq = 0;

        // burst request withdrawn before grant keeps hrq (R10)
        auto_grant = 0; hlda = 0;
        wr(0, 16'h0020); wr(1, 16'd2); wr(2, 16'b101);
        dreq = 1;
        repeat (2) @(negedge clk);
        dreq = 0;
        repeat (2) @(negedge clk);
        cmp("R10 burst holds hrq", hrq, 1);
        clear_obs();
        dreq = 1; auto_grant = 1;
        wait_tc();
        cmp("R10 burst completes", words, 2);
        dreq = 0;

        // zero count enable (R12)
        clear_obs();
        wr(1, 16'd0); wr(2, 16'b001);
        dreq = 1;
        repeat (8) @(negedge clk);
        cmp("R12 zero count no request", hrq_rises, 0);
        dreq = 0;

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule